// File: doc/BRIEF.md
# Serial EEPROM Word Read Master

This block reads one 16-bit word from a three-wire serial EEPROM. A one-cycle request carries an 8-bit word address. The block then drives chip select, serial clock and serial data-out through a fixed read frame and samples the EEPROM's data-in line. When the frame is finished it presents the assembled word together with a single-cycle completion strobe.

The frame has a fixed shape. First comes a dummy clock pulse with select high and data low. Next come a start bit of 1, the read opcode (1 then 0), and the address, most significant bit first. Sixteen clock pulses then shift the word out of the memory, and data-in is captured each time the clock has returned low. A short deselect tail ends the frame, and the pins are left with the clock high and select low. Every pin state is held for `SETTLE` system clocks before the next one is applied, so the serial rate can suit slow parts.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset, chip select, serial clock and data-out are low, busy and done are low and the returned word is zero.
- R2: A request while idle makes busy high from the next clock. The first pin state of the frame has all three lines low.
- R3: Each pin state of the frame is held for exactly SETTLE system clocks. A frame has 63 pin states, so busy lasts 63*SETTLE clocks.
- R4: After the all-low state, select rises with the clock low. One full clock pulse with data-out low follows. Then a start bit of 1 and the opcode bits 1 and 0 are each held on data-out while the clock pulses high.
- R5: The 8 address bits are sent most significant bit first. Each bit is placed on data-out with the clock low, then the clock is raised with the bit unchanged.
- R6: After one idle low-clock state, 16 clock pulses (high, then low) read the word. Data-in is sampled at the end of each low phase, and the first sample is the most significant bit of the returned word.
- R7: The frame ends with all lines low, then select alone high, then all lines low, then the clock alone high. The pins keep that last state while idle.
- R8: done is high for exactly one clock, in the clock after the last pin state, with busy low and the read word valid on rd_data.
- R9: A request arriving while busy is ignored: the frame in progress and the returned word are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a read (taken only when idle) |
| req_addr | input | ADDR_W | Word address of the read |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Word read from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The bench issues reads at the addresses 0x00, 0xFF, 0x80, 0x01, 0xA5 and 0x5A, and compares the pins on every clock against a trace built independently from the frame description. All-zero and all-one addresses show whether the address bits are driven at all. Single-bit addresses at either end tell MSB-first order apart from LSB-first order. The alternating patterns expose bits that are shifted or swapped in the address and in the returned word. A behavioural EEPROM answers with an address-dependent word, so a wrong sample point or a wrong bit order shows up in rd_data. A second request injected in the middle of a frame must leave both the pin trace and the result of the first read unchanged.

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader #(
  parameter int SETTLE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int PRE      = 10;
  localparam int ADDR_END = PRE + 2*ADDR_W;
  localparam int DATA0    = ADDR_END + 1;
  localparam int DATA_END = DATA0 + 2*DATA_W;
  localparam int LAST     = DATA_END + 3;
  localparam int SW       = $clog2(LAST + 2);
  localparam int CW       = $clog2(SETTLE + 1);

  // returns {cs, di, sk}
  function automatic logic [2:0] step_word(input int s, input logic [ADDR_W-1:0] a);
    int k;
    logic [2:0] w;
    case (s)
      0: w = 3'b000;
      1: w = 3'b100;
      2: w = 3'b101;
      3: w = 3'b100;
      4: w = 3'b110;
      5: w = 3'b111;
      6: w = 3'b110;
      7: w = 3'b111;
      8: w = 3'b100;
      9: w = 3'b101;
      default: begin
        w = 3'b000;
        if (s < ADDR_END) begin
          k = s - PRE;
          w = {1'b1, a[ADDR_W-1-k/2], (k % 2) == 1};
        end else if (s == ADDR_END) begin
          w = 3'b100;
        end else if (s < DATA_END) begin
          k = s - DATA0;
          w = {1'b1, 1'b0, (k % 2) == 0};
        end else if (s == DATA_END + 1) begin
          w = 3'b100;
        end else if (s == DATA_END + 3) begin
          w = 3'b001;
        end
      end
    endcase
    return w;
  endfunction

  logic [SW-1:0]     step;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] shift;
  logic              step_end, sample;
  int                si;

  assign si       = int'(step);
  assign step_end = busy && (int'(cnt) == SETTLE - 1);
  assign sample   = step_end && si >= DATA0 && si < DATA_END && ((si - DATA0) % 2) == 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      step    <= '0;
      cnt     <= '0;
      addr_q  <= '0;
      shift   <= '0;
      rd_data <= '0;
      {ee_cs, ee_di, ee_sk} <= 3'b000;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy   <= 1'b1;
          step   <= '0;
          cnt    <= '0;
          addr_q <= req_addr;
          {ee_cs, ee_di, ee_sk} <= step_word(0, req_addr);
        end
      end else if (step_end) begin
        cnt <= '0;
        if (sample) shift <= {shift[DATA_W-2:0], ee_do};
        if (si == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rd_data <= shift;
        end else begin
          step <= step + 1'b1;
          {ee_cs, ee_di, ee_sk} <= step_word(si + 1, addr_q);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_end) |=> $stable({ee_cs, ee_di, ee_sk}));
  assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> $stable({ee_cs, ee_di, ee_sk}));
  assert_select_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_sk);
  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ee_sk) && ee_cs) |-> $stable(ee_di));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_end) |=> (busy && $stable(step)));

endmodule

// File: tb/eeprom_word_reader_bench.sv
module eeprom_word_reader_bench;
  localparam int SETTLE = 3;
  localparam int STEPS  = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [7:0] req_addr = '0;
  logic busy, done, ee_cs, ee_sk, ee_di;
  logic [15:0] rd_data;
  logic ee_do;

  int tests = 0;
  int fails = 0;
  logic [2:0] exp_q[$];

  always #10 clk = ~clk;

  eeprom_word_reader #(.SETTLE(SETTLE), .ADDR_W(8), .DATA_W(16)) u_eeprom_word_reader (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .busy(busy), .done(done), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  function automatic logic [15:0] mem_word(input logic [7:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction

  // behavioural EEPROM
  int       ph, nb, di_idx;
  logic [9:0]  cmd;
  logic [15:0] word;
  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      ph = 0; nb = 0; di_idx = 0; cmd = '0; ee_do = 1'b0;
    end else if (ph == 0) begin
      if (ee_di) begin ph = 1; nb = 0; end
    end else if (ph == 1) begin
      cmd = {cmd[8:0], ee_di};
      nb++;
      if (nb == 10) begin
        ph = 2; di_idx = 15;
        word = (cmd[9:8] == 2'b10) ? mem_word(cmd[7:0]) : 16'h0000;
      end
    end else if (ph == 2) begin
      ee_do = (di_idx >= 0) ? word[di_idx] : 1'b0;
      di_idx--;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic push(input logic cs, input logic d, input logic c);
    for (int i = 0; i < SETTLE; i++) exp_q.push_back({cs, d, c});
  endtask

  task automatic build(input logic [7:0] a);
    exp_q.delete();
    push(0,0,0); push(1,0,0); push(1,0,1); push(1,0,0);
    push(1,1,0); push(1,1,1);
    push(1,1,0); push(1,1,1); push(1,0,0); push(1,0,1);
    for (int b = 7; b >= 0; b--) begin push(1,a[b],0); push(1,a[b],1); end
    push(1,0,0);
    for (int b = 0; b < 16; b++) begin push(1,0,1); push(1,0,0); end
    push(0,0,0); push(1,0,0); push(0,0,0); push(0,0,1);
  endtask

  // inject: cycle index at which a second request is pulsed (-1 none)
  task automatic do_read(input logic [7:0] a, input int inject);
    int cyc;
    logic [2:0] e;
    build(a);
    @(negedge clk); req = 1'b1; req_addr = a;
    @(negedge clk); req = 1'b0; req_addr = ~a;
    cyc = 0;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      if (cyc == 0) check("R2 first state", {ee_cs, ee_di, ee_sk}, 3'b000);
      check("R3 R4 R5 R6 R7 pin trace", {ee_cs, ee_di, ee_sk}, e);
      if (!busy || done) check("R3 busy during frame", {busy, done}, 2'b10);
      if (cyc == inject) begin req = 1'b1; req_addr = ~a; end
      @(negedge clk);
      req = 1'b0;
      cyc++;
    end
    check("R8 done pulse", {done, busy}, 2'b10);
    check("R6 R9 read word", rd_data, mem_word(a));
    @(negedge clk);
    check("R8 done single cycle", done, 1'b0);
    check("R7 idle pins", {ee_cs, ee_di, ee_sk}, 3'b001);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 reset pins", {ee_cs, ee_di, ee_sk}, 3'b000);
        check("R1 reset status", {busy, done}, 2'b00);
        check("R1 reset data", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle without request", busy, 1'b0);
        do_read(8'h00, -1);
        do_read(8'hFF, -1);
        do_read(8'h80, -1);
        do_read(8'h01, -1);
        do_read(8'hA5, 40);
        do_read(8'h5A, 120);
        repeat (5) @(negedge clk);
        check("R7 pins held while idle", {ee_cs, ee_di, ee_sk}, 3'b001);
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule